// File: doc/BRIEF.md
# Rotating-Broadcast Partial Sum Node

This block runs one compute node in a row of peers that share a broadcast bus. The input channels are split across the nodes, so no node can finish a dot product on its own channel slice. Each node keeps a weight segment for its own output lanes. The segment covers the channel slices of every peer. Partial products are summed into a per-lane accumulator as the peers' slices pass by, one peer at a time.

Before a job, the weights for every source slice and the node's own activation slice are written through preload ports. A start pulse clears the accumulators. The node then first consumes its own slice locally, one word per cycle, with every lane working in parallel. After that it walks through the broadcast turns, beginning with turn 0. On the turn that matches its index, it sends its slice out on the transmit side of the bus. On every other turn, it takes in the broadcaster's words and accumulates them against the weights held for that source. When the final turn completes, the node pulses done and holds its results.

Top module: `bcast_accum_node`

## Requirements
- R1: The weight port stores a signed value at (source node `wt_src`, word `wt_word`, lane `wt_lane`). That value is used whenever a word with that index from that source is accumulated into that lane.
- R2: A start pulse while idle clears every accumulator and sets `busy`. For the next SLICE_LEN cycles the node accumulates its own slice with no bus activity. After that, each lane holds exactly the local partial sum.
- R3: Broadcast turns run in order from 0 to NUM_NODES-1. On its own turn the node presents slice words 0 to SLICE_LEN-1 in order on `tx_data` with `tx_valid` high. A word that is not yet accepted stays stable until `tx_ready` is seen.
- R4: On its own turn the node keeps `rx_ready` low and accumulates nothing. `tx_valid` and `rx_ready` are never high together.
- R5: On every other turn `rx_ready` is high. Each accepted word x at position k from source s adds x times weight(s,k,j) into lane j.
- R6: A turn advances only after all SLICE_LEN words of that turn have been handshaken.
- R7: Every accumulation step is a saturating signed add, clamped to the ACC_W range at that step.
- R8: `done` is high for exactly one cycle, in the cycle after the last word of the last turn is accepted. `busy` is low while `done` is high.
- R9: After a job, `acc_out` holds its value and bus words are refused until the next start.
- R10: After reset, `busy`, `done`, `tx_valid` and `rx_ready` are low and `acc_out` is zero.
- R11: `acc_out` packs lane j at bits [j*ACC_W +: ACC_W]. `act_we` writes slice word `act_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| node_idx | input | IDX_W | Index of this node in the row |
| wt_we | input | 1 | Weight write strobe |
| wt_src | input | IDX_W | Source node of the weight |
| wt_word | input | WORD_W | Word position within the slice |
| wt_lane | input | LANE_W | Output lane |
| wt_data | input | DATA_W | Signed weight |
| act_we | input | 1 | Local slice write strobe |
| act_word | input | WORD_W | Local slice word position |
| act_data | input | DATA_W | Signed activation word |
| start | input | 1 | Begin a job (accepted when idle) |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| tx_valid | output | 1 | Own slice word offered on bus |
| tx_ready | input | 1 | All receivers accept the word |
| tx_data | output | DATA_W | Own slice word |
| rx_valid | input | 1 | Broadcaster word present |
| rx_ready | output | 1 | Node accepts broadcaster word |
| rx_data | input | DATA_W | Broadcaster word |
| acc_out | output | NUM_LANES*ACC_W | Packed lane accumulators |

## Verification
The assertions check, on every cycle, that sending and receiving never overlap, that the done pulse lasts one cycle with busy low, that results stay frozen while idle, that a stalled transmit word holds, and that start clears the accumulators. Only the bench's scenarios can show the arithmetic and the ordering. These are the local-first partial sum, the source-dependent weight selection, the turn order seen through the transmit slot, saturation along the exact accumulation sequence, and the timing of the done cycle relative to the last handshake.

// File: rtl/bcast_accum_pkg.sv
`timescale 1ns/1ps
package bcast_accum_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOCAL = 2'd1,
        ST_TURN  = 2'd2,
        ST_DONE  = 2'd3
    } node_state_e;
endpackage

// File: rtl/bcast_wstore.sv
`timescale 1ns/1ps
module bcast_wstore #(
    parameter int NUM_NODES = 4,
    parameter int SLICE_LEN = 4,
    parameter int NUM_LANES = 2,
    parameter int DATA_W    = 8,
    localparam int IDX_W  = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1,
    localparam int WORD_W = (SLICE_LEN > 1) ? $clog2(SLICE_LEN) : 1,
    localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [IDX_W-1:0]              wsrc,
    input  logic [WORD_W-1:0]             wword,
    input  logic [LANE_W-1:0]             wlane,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [IDX_W-1:0]              rsrc,
    input  logic [WORD_W-1:0]             rword,
    output logic [NUM_LANES*DATA_W-1:0]   rdata
);
    localparam int ROWS = NUM_NODES * SLICE_LEN;

    logic [ROWS-1:0][NUM_LANES-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        int wr_row;
        int rd_row;
        mem_d  = mem_q;
        wr_row = int'(wsrc) * SLICE_LEN + int'(wword);
        rd_row = int'(rsrc) * SLICE_LEN + int'(rword);
        if (we && int'(wsrc) < NUM_NODES && int'(wword) < SLICE_LEN
               && int'(wlane) < NUM_LANES) begin
            mem_d[wr_row][wlane] = wdata;
        end
        if (rd_row < ROWS) rdata = mem_q[rd_row];
        else               rdata = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end
endmodule

// File: rtl/bcast_mac_lane.sv
`timescale 1ns/1ps
module bcast_mac_lane #(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 16
) (
    input  logic signed [ACC_W-1:0]  acc_in,
    input  logic signed [DATA_W-1:0] x,
    input  logic signed [DATA_W-1:0] w,
    output logic        [ACC_W-1:0]  acc_sum
);
    localparam int PROD_W = 2 * DATA_W;
    localparam int SUM_W  = ((ACC_W > PROD_W) ? ACC_W : PROD_W) + 1;
    localparam logic signed [SUM_W-1:0] MAX_S =
        $signed({{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}});
    localparam logic signed [SUM_W-1:0] MIN_S =
        $signed({{(SUM_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}});

    logic signed [PROD_W-1:0] prod;
    logic signed [SUM_W-1:0]  sum;

    always_comb begin
        prod = x * w;
        sum  = $signed({{(SUM_W-ACC_W){acc_in[ACC_W-1]}}, acc_in})
             + $signed({{(SUM_W-PROD_W){prod[PROD_W-1]}}, prod});
        if (sum > MAX_S)      acc_sum = MAX_S[ACC_W-1:0];
        else if (sum < MIN_S) acc_sum = MIN_S[ACC_W-1:0];
        else                  acc_sum = sum[ACC_W-1:0];
    end
endmodule

// File: rtl/bcast_accum_node.sv
`timescale 1ns/1ps
module bcast_accum_node
    import bcast_accum_pkg::*;
#(
    parameter int NUM_NODES = 4,
    parameter int SLICE_LEN = 4,
    parameter int NUM_LANES = 2,
    parameter int DATA_W    = 8,
    parameter int ACC_W     = 16,
    localparam int IDX_W  = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1,
    localparam int WORD_W = (SLICE_LEN > 1) ? $clog2(SLICE_LEN) : 1,
    localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IDX_W-1:0]             node_idx,
    input  logic                         wt_we,
    input  logic [IDX_W-1:0]             wt_src,
    input  logic [WORD_W-1:0]            wt_word,
    input  logic [LANE_W-1:0]            wt_lane,
    input  logic [DATA_W-1:0]            wt_data,
    input  logic                         act_we,
    input  logic [WORD_W-1:0]            act_word,
    input  logic [DATA_W-1:0]            act_data,
    input  logic                         start,
    output logic                         busy,
    output logic                         done,
    output logic                         tx_valid,
    input  logic                         tx_ready,
    output logic [DATA_W-1:0]            tx_data,
    input  logic                         rx_valid,
    output logic                         rx_ready,
    input  logic [DATA_W-1:0]            rx_data,
    output logic [NUM_LANES*ACC_W-1:0]   acc_out
);
    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(SLICE_LEN - 1);
    localparam logic [IDX_W-1:0]  LAST_TURN = IDX_W'(NUM_NODES - 1);

    typedef struct packed {
        node_state_e                          st;
        logic [IDX_W-1:0]                     turn;
        logic [WORD_W-1:0]                    word;
        logic [NUM_LANES-1:0][ACC_W-1:0]      acc;
        logic [SLICE_LEN-1:0][DATA_W-1:0]     slice;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                             own_turn;
    logic                             mac_en;
    logic                             step;
    logic [DATA_W-1:0]                mac_x;
    logic [IDX_W-1:0]                 rd_src;
    logic [NUM_LANES*DATA_W-1:0]      rd_w;
    logic [NUM_LANES-1:0][ACC_W-1:0]  mac_sum;

    bcast_wstore #(
        .NUM_NODES(NUM_NODES), .SLICE_LEN(SLICE_LEN),
        .NUM_LANES(NUM_LANES), .DATA_W(DATA_W)
    ) u_wstore (
        .clk(clk), .rst_n(rst_n),
        .we(wt_we), .wsrc(wt_src), .wword(wt_word), .wlane(wt_lane), .wdata(wt_data),
        .rsrc(rd_src), .rword(ctl_q.word), .rdata(rd_w)
    );

    for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
        bcast_mac_lane #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_lane (
            .acc_in (ctl_q.acc[j]),
            .x      (mac_x),
            .w      (rd_w[j*DATA_W +: DATA_W]),
            .acc_sum(mac_sum[j])
        );
    end

    always_comb begin
        own_turn = (ctl_q.st == ST_TURN) && (ctl_q.turn == node_idx);
        tx_valid = own_turn;
        tx_data  = ctl_q.slice[ctl_q.word];
        rx_ready = (ctl_q.st == ST_TURN) && !own_turn;
        busy     = (ctl_q.st == ST_LOCAL) || (ctl_q.st == ST_TURN);
        done     = (ctl_q.st == ST_DONE);
        acc_out  = ctl_q.acc;
        mac_x    = (ctl_q.st == ST_LOCAL) ? ctl_q.slice[ctl_q.word] : rx_data;
        rd_src   = (ctl_q.st == ST_LOCAL) ? node_idx : ctl_q.turn;
        mac_en   = (ctl_q.st == ST_LOCAL) || (rx_ready && rx_valid);
        step     = mac_en || (tx_valid && tx_ready);

        ctl_d = ctl_q;
        if (act_we && int'(act_word) < SLICE_LEN) begin
            ctl_d.slice[act_word] = act_data;
        end
        if (mac_en) ctl_d.acc = mac_sum;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st   = ST_LOCAL;
                    ctl_d.turn = '0;
                    ctl_d.word = '0;
                    ctl_d.acc  = '0;
                end
            end
            ST_LOCAL, ST_TURN: begin
                if (step) begin
                    if (ctl_q.word == LAST_WORD) begin
                        ctl_d.word = '0;
                        if (ctl_q.st == ST_LOCAL) begin
                            ctl_d.st = ST_TURN;
                        end else if (ctl_q.turn == LAST_TURN) begin
                            ctl_d.st = ST_DONE;
                        end else begin
                            ctl_d.turn = ctl_q.turn + 1'b1;
                        end
                    end else begin
                        ctl_d.word = ctl_q.word + 1'b1;
                    end
                end
            end
            ST_DONE: ctl_d.st = ST_IDLE;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st    <= ST_IDLE;
            ctl_q.turn  <= '0;
            ctl_q.word  <= '0;
            ctl_q.acc   <= '0;
            ctl_q.slice <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/bcast_accum_node_chk.sv
`timescale 1ns/1ps
module bcast_accum_node_chk #(
    parameter int ACC_BITS = 32,
    parameter int DATA_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic                tx_valid,
    input logic                tx_ready,
    input logic [DATA_W-1:0]   tx_data,
    input logic                rx_ready,
    input logic                act_we,
    input logic [ACC_BITS-1:0] acc_out
);
    assert_no_rx_on_own_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && rx_ready));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_result_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(acc_out));

    assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !act_we) |=> (tx_valid && $stable(tx_data)));

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> (busy && acc_out == '0));

    assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind bcast_accum_node bcast_accum_node_chk #(
    .ACC_BITS(NUM_LANES*ACC_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_ready(rx_ready), .act_we(act_we), .acc_out(acc_out)
);

// File: tb/bcast_accum_node_tb.sv
`timescale 1ns/1ps
module bcast_accum_node_tb;
    localparam int N = 4, L = 4, M = 2, DW = 8, AW = 16;
    localparam int AMAX = 32767, AMIN = -32768;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] node_idx = '0;
    logic wt_we = 0; logic [1:0] wt_src = '0; logic [1:0] wt_word = '0;
    logic wt_lane = 0; logic [DW-1:0] wt_data = '0;
    logic act_we = 0; logic [1:0] act_word = '0; logic [DW-1:0] act_data = '0;
    logic start = 0, busy, done, tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;
    logic [DW-1:0] tx_data, rx_data = '0;
    logic [M*AW-1:0] acc_out;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    bcast_accum_node #(.NUM_NODES(N), .SLICE_LEN(L), .NUM_LANES(M),
                       .DATA_W(DW), .ACC_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .node_idx(node_idx),
        .wt_we(wt_we), .wt_src(wt_src), .wt_word(wt_word), .wt_lane(wt_lane), .wt_data(wt_data),
        .act_we(act_we), .act_word(act_word), .act_data(act_data),
        .start(start), .busy(busy), .done(done),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .acc_out(acc_out));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int xval(int mode, int s, int k);
        case (mode)
            0: return ((s*37 + k*11 + 3) % 256) - 128;
            1: return 127;
            2: return -128;
            default: return (s % 2 == 1) ? -128 : 127;
        endcase
    endfunction

    function automatic int wval(int mode, int s, int k, int j);
        if (mode == 0) return ((s*13 + k*29 + j*71 + 5) % 256) - 128;
        return 127;
    endfunction

    function automatic int sat(int v);
        if (v > AMAX) return AMAX;
        if (v < AMIN) return AMIN;
        return v;
    endfunction

    function automatic int lane(logic [M*AW-1:0] v, int j);
        logic signed [AW-1:0] t;
        t = v[j*AW +: AW];
        return int'(t);
    endfunction

    task automatic run_job(input int me, input int mode);
        int exp_loc [M];
        int exp_fin [M];
        int txk, rxk, cyc, last_x, s;
        bit seen_bus;
        logic [M*AW-1:0] held;
        // expected values, in the accumulation order of R2, R3, R5, R7
        for (int j = 0; j < M; j++) begin
            int a = 0;
            for (int k = 0; k < L; k++) a = sat(a + xval(mode, me, k) * wval(mode, me, k, j));
            exp_loc[j] = a;
            for (int src = 0; src < N; src++)
                if (src != me)
                    for (int k = 0; k < L; k++) a = sat(a + xval(mode, src, k) * wval(mode, src, k, j));
            exp_fin[j] = a;
        end
        // R1 preload weights for every source, and R11 own slice
        @(negedge clk);
        node_idx = 2'(me);
        for (int src = 0; src < N; src++)
            for (int k = 0; k < L; k++)
                for (int j = 0; j < M; j++) begin
                    wt_we = 1; wt_src = 2'(src); wt_word = 2'(k); wt_lane = 1'(j);
                    wt_data = DW'(wval(mode, src, k, j));
                    @(negedge clk);
                end
        wt_we = 0;
        for (int k = 0; k < L; k++) begin
            act_we = 1; act_word = 2'(k); act_data = DW'(xval(mode, me, k));
            @(negedge clk);
        end
        act_we = 0;
        start = 1;
        @(negedge clk);
        start = 0;
        chk(busy == 1'b1 && acc_out == '0, "R2 clear on start", int'(acc_out[AW-1:0]), 0);
        txk = 0; rxk = 0; cyc = 1; last_x = 0; seen_bus = 0;
        forever begin
            if (!seen_bus && (rx_ready || tx_valid)) begin
                seen_bus = 1;
                chk(cyc == L + 1, "R2 local phase length", cyc, L + 1);
                for (int j = 0; j < M; j++)
                    chk(lane(acc_out, j) == exp_loc[j], "R2 local partial", lane(acc_out, j), exp_loc[j]);
            end
            if (tx_valid && rx_ready) chk(0, "R4 tx and rx together", 1, 0);
            if (done) break;
            tx_ready = (cyc % 4) != 1;
            if (tx_valid && tx_ready) begin
                if (txk == 0) chk(rxk == me * L, "R3 own turn position", rxk, me * L);
                chk(int'($signed(tx_data)) == xval(mode, me, txk), "R3 tx word",
                    int'($signed(tx_data)), xval(mode, me, txk));
                txk++; last_x = cyc;
            end
            rx_valid = (rxk < (N - 1) * L) && (((cyc + me) % 3) != 0);
            s = rxk / L; if (s >= me) s++;
            rx_data = DW'(xval(mode, s, rxk % L));
            if (rx_valid && rx_ready) begin rxk++; last_x = cyc; end
            @(negedge clk);
            cyc++;
            if (cyc > 500) begin chk(0, "R8 job never finished", cyc, 0); break; end
        end
        rx_valid = 0; tx_ready = 0;
        chk(done == 1'b1 && busy == 1'b0, "R8 done with busy low", int'(busy), 0);
        chk(cyc == last_x + 1, "R8 done timing", cyc, last_x + 1);
        chk(txk == L && rxk == (N - 1) * L, "R6 all words handshaken", txk + rxk, N * L);
        for (int j = 0; j < M; j++)
            chk(lane(acc_out, j) == exp_fin[j], (mode == 0) ? "R1 R5 final sum" : "R7 saturated sum",
                lane(acc_out, j), exp_fin[j]);
        held = acc_out;
        for (int c = 0; c < 3; c++) begin
            rx_valid = 1; rx_data = 8'h37; tx_ready = 1;
            @(negedge clk);
            if (c == 0) chk(done == 1'b0, "R8 done single cycle", int'(done), 0);
            chk(acc_out == held && rx_ready == 1'b0 && tx_valid == 1'b0, "R9 frozen result",
                lane(acc_out, 0), lane(held, 0));
        end
        rx_valid = 0; tx_ready = 0;
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && tx_valid == 0 && rx_ready == 0 && acc_out == '0,
            "R10 reset state", int'(busy) + int'(done) + int'(tx_valid) + int'(rx_ready), 0);
        for (int me = 0; me < N; me++)
            for (int mode = 0; mode < 4; mode++)
                run_job(me, mode);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule